// File: doc/BRIEF.md
# Clock-Control System Register Bank

A bank of 32-bit control words behind an APB slave port. It stores the clock, PLL and memory-remap control words of a subsystem. Most words are plain read/write storage. A few follow their own rules. The PLL status word is read-only. The three remap words cannot be changed by any write. The fabric-clock divider word takes its reset value from two elaboration-time bus-divisor parameters, translated through a non-linear code.

The word index is the byte address with its two low bits removed. Indices past the implemented count read as zero, absorb writes and raise PSLVERR. Each transfer uses one setup cycle and one access cycle, with PREADY always high. When a write tries to change a remap word, the block raises a one-cycle `remap_reject` pulse. This is the only trace such a write leaves.

Top module: `clkctl_sysreg_bank`

## Requirements
- R1: The word index is `paddr[ADDR_W-1:2]`. The two low address bits have no effect on which word is read or written.
- R2: A read whose word index is `NUM_REGS` or more returns zero with `pslverr` high in the access phase. `pready` is high in every access phase.
- R3: A write whose word index is `NUM_REGS` or more changes no word, including words whose low index bits alias it, and raises `pslverr`.
- R4: The PLL status word (index `IDX_PLL_STAT`, default 15) resets to 0x0000_0003 and ignores all writes.
- R5: The PLL low-configuration word (index `IDX_PLL_LOW`, default 14) resets to 0x021A_2358 and stores any written value.
- R6: The remap words (indices `IDX_ESRAM`, `IDX_DDR`, `IDX_REMAP`, defaults 0, 1, 2) reset to zero and keep their contents on every write. A write with data different from the stored value pulses `remap_reject` high for exactly the cycle after the access cycle. A write of the same value leaves it low.
- R7: The divider word (index `IDX_DIV`, default 9) resets to `code(APB0_DIV)` in bits 7:5 and `code(APB1_DIV)` in bits 4:2, with all other bits zero. The default divisors 2 and 2 give 0x0000_0024.
- R8: The divisor code maps 1→0, 2→1, 4→2, 8→4, 16→5 and 32→6. Below 8 it is the trailing-zero count; from 8 up it is one more. Any divisor that is not a power of two up to 32 stops elaboration.
- R9: Every other in-range word resets to zero and stores all 32 written bits.
- R10: Read data and `pslverr` are registered at the setup edge and valid throughout the access phase. `pslverr` is low for in-range indices.
- R11: The reset is synchronous and active-high. It restores every word to its reset value, whatever was written before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Registered read data |
| pready | output | 1 | Always high |
| pslverr | output | 1 | Out-of-range index flag |
| remap_reject | output | 1 | One-cycle pulse on an attempted remap-word change |

## Verification
Corrupted state shows up at the ports on the first read of the affected word. A wrong write enable or a broken alias guard appears in the next read of the word it hit. A bad reset constant appears in the first read after reset. Remap and PLL status words that drift show up in random reads, and the bound assertions catch that drift in the cycle it happens. A divisor code error shows in a single read of the divider word from instances built with every legal divisor pair.

// File: rtl/clkctl_sysreg_pkg.sv
package clkctl_sysreg_pkg;

  localparam int DATA_W = 32;

  // Value loaded into the PLL status word and PLL low-configuration word.
  localparam logic [DATA_W-1:0] PLL_STAT_RST = 32'h0000_0003;
  localparam logic [DATA_W-1:0] PLL_LOW_RST  = 32'h021A_2358;

  // Bit positions of the two divisor codes inside the divider word.
  localparam int DIV0_LSB = 5;
  localparam int DIV1_LSB = 2;

  typedef enum logic [1:0] {
    WK_PLAIN    = 2'd0,
    WK_READONLY = 2'd1,
    WK_LOCKED   = 2'd2
  } word_kind_e;

  // Power of two, between 1 and 32.
  function automatic bit div_legal(input int unsigned d);
    return (d >= 1) && (d <= 32) && ((d & (d - 1)) == 0);
  endfunction

  // Trailing zeros; from a divisor of 8 upward one code value is skipped.
  function automatic logic [2:0] div_code(input int unsigned d);
    int unsigned tz;
    tz = 0;
    for (int k = 5; k >= 0; k--) begin
      if (d == (32'd1 << k)) tz = k;
    end
    if (d >= 8) tz = tz + 1;
    return 3'(tz);
  endfunction

endpackage

// File: rtl/sysreg_addr_dec.sv
module sysreg_addr_dec #(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 24,
  localparam int WORD_W  = ADDR_W - 2,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic [ADDR_W-1:0] paddr,
  output logic [IDX_W-1:0]  idx,
  output logic              in_range
);

  localparam logic [WORD_W-1:0] LIMIT = WORD_W'(NUM_REGS);

  logic [WORD_W-1:0] word;

  // Byte address to word index: the two low bits play no part.
  assign word     = paddr[ADDR_W-1:2];
  assign in_range = (word < LIMIT);
  assign idx      = word[IDX_W-1:0];

endmodule

// File: rtl/sysreg_write_ctrl.sv
module sysreg_write_ctrl
  import clkctl_sysreg_pkg::*;
#(
  parameter int NUM_REGS     = 24,
  parameter int IDX_ESRAM    = 0,
  parameter int IDX_DDR      = 1,
  parameter int IDX_REMAP    = 2,
  parameter int IDX_PLL_STAT = 15,
  localparam int IDX_W       = $clog2(NUM_REGS)
) (
  input  logic                pclk,
  input  logic                rst,
  input  logic                wr_fire,
  input  logic                in_range,
  input  logic [IDX_W-1:0]    idx,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W-1:0]   cur_data,
  output logic [NUM_REGS-1:0] we,
  output logic                reject_q
);

  logic [NUM_REGS-1:0] locked_hit;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_kind
    localparam word_kind_e KIND =
      (g == IDX_PLL_STAT) ? WK_READONLY :
      ((g == IDX_ESRAM) || (g == IDX_DDR) || (g == IDX_REMAP)) ? WK_LOCKED :
      WK_PLAIN;

    logic sel;
    assign sel = wr_fire && in_range && (idx == IDX_W'(g));

    if (KIND == WK_PLAIN) begin : g_plain
      assign we[g]         = sel;
      assign locked_hit[g] = 1'b0;
    end else if (KIND == WK_LOCKED) begin : g_locked
      assign we[g]         = 1'b0;
      assign locked_hit[g] = sel;
    end else begin : g_ro
      assign we[g]         = 1'b0;
      assign locked_hit[g] = 1'b0;
    end
  end

  // A change attempt on a remap word is flagged for one cycle.
  always_ff @(posedge pclk) begin
    if (rst) reject_q <= 1'b0;
    else     reject_q <= (|locked_hit) && (wdata != cur_data);
  end

endmodule

// File: rtl/sysreg_store.sv
module sysreg_store
  import clkctl_sysreg_pkg::*;
#(
  parameter int NUM_REGS            = 24,
  parameter int IDX_PLL_STAT        = 15,
  parameter int IDX_PLL_LOW         = 14,
  parameter int IDX_DIV             = 9,
  parameter logic [DATA_W-1:0] DIV_RST = 32'h0000_0024
) (
  input  logic                           pclk,
  input  logic                           rst,
  input  logic [NUM_REGS-1:0]            we,
  input  logic [DATA_W-1:0]              wdata,
  output logic [NUM_REGS-1:0][DATA_W-1:0] bank_q
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    localparam logic [DATA_W-1:0] RV =
      (g == IDX_PLL_STAT) ? PLL_STAT_RST :
      (g == IDX_PLL_LOW)  ? PLL_LOW_RST  :
      (g == IDX_DIV)      ? DIV_RST      : '0;

    logic [DATA_W-1:0] q;

    always_ff @(posedge pclk) begin
      if (rst)        q <= RV;
      else if (we[g]) q <= wdata;
    end

    assign bank_q[g] = q;
  end

endmodule

// File: rtl/sysreg_rd_port.sv
module sysreg_rd_port
  import clkctl_sysreg_pkg::*;
(
  input  logic              pclk,
  input  logic              rst,
  input  logic              setup,
  input  logic              in_range,
  input  logic [DATA_W-1:0] sel_data,
  output logic [DATA_W-1:0] prdata_q,
  output logic              pslverr_q
);

  // Captured at the setup edge so the access phase sees flopped values.
  always_ff @(posedge pclk) begin
    if (rst) begin
      prdata_q  <= '0;
      pslverr_q <= 1'b0;
    end else if (setup) begin
      prdata_q  <= in_range ? sel_data : '0;
      pslverr_q <= !in_range;
    end
  end

endmodule

// File: rtl/clkctl_sysreg_bank.sv
module clkctl_sysreg_bank
  import clkctl_sysreg_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int NUM_REGS     = 24,
  parameter int APB0_DIV     = 2,
  parameter int APB1_DIV     = 2,
  parameter int IDX_ESRAM    = 0,
  parameter int IDX_DDR      = 1,
  parameter int IDX_REMAP    = 2,
  parameter int IDX_DIV      = 9,
  parameter int IDX_PLL_LOW  = 14,
  parameter int IDX_PLL_STAT = 15
) (
  input  logic              pclk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              remap_reject
);

  localparam int IDX_W = $clog2(NUM_REGS);
  localparam logic [DATA_W-1:0] DIV_RST =
    (DATA_W'(div_code(APB0_DIV)) << DIV0_LSB) |
    (DATA_W'(div_code(APB1_DIV)) << DIV1_LSB);

  if (!div_legal(APB0_DIV) || !div_legal(APB1_DIV)) begin : g_bad_div
    $error("bus divisors must be powers of two no larger than 32");
  end

  logic [IDX_W-1:0]                idx;
  logic                            in_range;
  logic [NUM_REGS-1:0]             we;
  logic [NUM_REGS-1:0][DATA_W-1:0] bank_q;
  logic [DATA_W-1:0]               sel_data;
  logic                            setup;
  logic                            wr_fire;

  assign setup   = psel && !penable;
  assign wr_fire = psel && penable && pwrite;
  assign sel_data = in_range ? bank_q[idx] : '0;
  assign pready  = 1'b1;

  sysreg_addr_dec #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
    .paddr    (paddr),
    .idx      (idx),
    .in_range (in_range)
  );

  sysreg_write_ctrl #(
    .NUM_REGS(NUM_REGS), .IDX_ESRAM(IDX_ESRAM), .IDX_DDR(IDX_DDR),
    .IDX_REMAP(IDX_REMAP), .IDX_PLL_STAT(IDX_PLL_STAT)
  ) u_wr (
    .pclk     (pclk),
    .rst      (rst),
    .wr_fire  (wr_fire),
    .in_range (in_range),
    .idx      (idx),
    .wdata    (pwdata),
    .cur_data (sel_data),
    .we       (we),
    .reject_q (remap_reject)
  );

  sysreg_store #(
    .NUM_REGS(NUM_REGS), .IDX_PLL_STAT(IDX_PLL_STAT),
    .IDX_PLL_LOW(IDX_PLL_LOW), .IDX_DIV(IDX_DIV), .DIV_RST(DIV_RST)
  ) u_store (
    .pclk   (pclk),
    .rst    (rst),
    .we     (we),
    .wdata  (pwdata),
    .bank_q (bank_q)
  );

  sysreg_rd_port u_rd (
    .pclk      (pclk),
    .rst       (rst),
    .setup     (setup),
    .in_range  (in_range),
    .sel_data  (sel_data),
    .prdata_q  (prdata),
    .pslverr_q (pslverr)
  );

endmodule

// File: rtl/clkctl_sysreg_chk.sv
module clkctl_sysreg_chk #(
  parameter int ADDR_W       = 8,
  parameter int NUM_REGS     = 24,
  parameter int IDX_ESRAM    = 0,
  parameter int IDX_DDR      = 1,
  parameter int IDX_REMAP    = 2,
  parameter int IDX_PLL_LOW  = 14,
  parameter int IDX_PLL_STAT = 15
) (
  input logic                     pclk,
  input logic                     rst,
  input logic                     psel,
  input logic                     penable,
  input logic                     pwrite,
  input logic [ADDR_W-1:0]        paddr,
  input logic [31:0]              pwdata,
  input logic [31:0]              prdata,
  input logic                     pslverr,
  input logic                     remap_reject,
  input logic [NUM_REGS-1:0][31:0] bank_q
);

  logic oor;
  logic access;
  assign oor    = (int'(paddr[ADDR_W-1:2]) >= NUM_REGS);
  assign access = psel && penable;

  p_oor_read_zero_r2: assert property (@(posedge pclk) disable iff (rst)
    access && oor && !pwrite |-> pslverr && (prdata == 32'h0));

  p_oor_write_err_r3: assert property (@(posedge pclk) disable iff (rst)
    access && oor && pwrite |-> pslverr);

  p_inrange_noerr_r10: assert property (@(posedge pclk) disable iff (rst)
    access && !oor |-> !pslverr);

  p_pll_stat_fixed_r4: assert property (@(posedge pclk) disable iff (rst)
    bank_q[IDX_PLL_STAT] == 32'h0000_0003);

  p_remap_fixed_r6: assert property (@(posedge pclk) disable iff (rst)
    (bank_q[IDX_ESRAM] | bank_q[IDX_DDR] | bank_q[IDX_REMAP]) == 32'h0);

  p_reject_single_r6: assert property (@(posedge pclk) disable iff (rst)
    remap_reject |=> !remap_reject);

  p_pll_low_store_r5: assert property (@(posedge pclk) disable iff (rst)
    access && pwrite && !oor && (int'(paddr[ADDR_W-1:2]) == IDX_PLL_LOW)
    |=> bank_q[IDX_PLL_LOW] == $past(pwdata));

endmodule

bind clkctl_sysreg_bank clkctl_sysreg_chk #(
  .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .IDX_ESRAM(IDX_ESRAM),
  .IDX_DDR(IDX_DDR), .IDX_REMAP(IDX_REMAP), .IDX_PLL_LOW(IDX_PLL_LOW),
  .IDX_PLL_STAT(IDX_PLL_STAT)
) u_chk (
  .pclk(pclk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pslverr(pslverr),
  .remap_reject(remap_reject), .bank_q(bank_q)
);

// File: tb/clkctl_sysreg_bank_tb_top.sv
module clkctl_sysreg_bank_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_REGS   = 24;
  localparam int I_ESRAM = 0, I_DDR = 1, I_REMAP = 2, I_DIV = 9;
  localparam int I_PLL_LOW = 14, I_PLL_STAT = 15;

  logic pclk = 1'b0;
  logic rst = 1'b1;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready, pslverr, remap_reject;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model [NUM_REGS];

  always #(CLK_PERIOD/2) pclk = ~pclk;

  clkctl_sysreg_bank dut_i (
    .pclk(pclk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .remap_reject(remap_reject)
  );

  // Divisor sweep: one instance per legal divisor pair, sharing the bus.
  logic [31:0] sw_rdata [36];
  logic        sw_rdy [36], sw_err [36], sw_rej [36];

  for (genvar i = 0; i < 6; i++) begin : g_a
    for (genvar j = 0; j < 6; j++) begin : g_b
      clkctl_sysreg_bank #(.APB0_DIV(1 << i), .APB1_DIV(1 << j)) sw_i (
        .pclk(pclk), .rst(rst), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(sw_rdata[i*6+j]), .pready(sw_rdy[i*6+j]),
        .pslverr(sw_err[i*6+j]), .remap_reject(sw_rej[i*6+j])
      );
    end
  end

  function automatic logic [31:0] code_of_log2(input int k);
    return (k < 3) ? 32'(k) : 32'(k + 1);
  endfunction

  function automatic logic [31:0] reset_of(input int w);
    if (w == I_PLL_STAT) return 32'h0000_0003;
    if (w == I_PLL_LOW)  return 32'h021A_2358;
    if (w == I_DIV)      return (code_of_log2(1) << 5) | (code_of_log2(1) << 2);
    return 32'h0;
  endfunction

  function automatic bit is_locked(input int w);
    return (w == I_ESRAM) || (w == I_DDR) || (w == I_REMAP);
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic apb_read(input logic [7:0] a, output logic [31:0] d,
                          output logic e, output logic r);
    @(negedge pclk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge pclk);
    penable = 1'b1;
    #1; d = prdata; e = pslverr; r = pready;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic apb_write(input logic [7:0] a, input logic [31:0] v,
                           output logic e, output logic rj);
    @(negedge pclk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = v;
    @(negedge pclk);
    penable = 1'b1;
    #1; e = pslverr;
    @(negedge pclk);
    rj = remap_reject;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge pclk); rst = 1'b1;
    repeat (3) @(negedge pclk);
    rst = 1'b0;
    for (int w = 0; w < NUM_REGS; w++) model[w] = reset_of(w);
  endtask

  task automatic model_write(input int w, input logic [31:0] v);
    if (w < NUM_REGS && w != I_PLL_STAT && !is_locked(w)) model[w] = v;
  endtask

  task automatic read_all(input string tag);
    logic [31:0] d; logic e, r;
    for (int w = 0; w < NUM_REGS; w++) begin
      apb_read(8'(w*4), d, e, r);
      check(d == model[w] && !e && r, tag, d, model[w]);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge pclk);
    fails++;
    $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] d, v; logic e, r, rj;
    int unsigned w;
    void'($urandom(32'd5813));
    do_reset();

    // R4 R5 R7 R9: reset values of every word
    read_all("R9/R4/R5/R7 reset value");

    // R4: PLL status ignores writes
    apb_write(8'(I_PLL_STAT*4), 32'hFFFF_0000, e, rj);
    apb_read(8'(I_PLL_STAT*4), d, e, r);
    check(d == 32'h3, "R4 pll status after write", d, 32'h3);

    // R5: PLL low word stores
    apb_write(8'(I_PLL_LOW*4), 32'hCAFE_0101, e, rj); model_write(I_PLL_LOW, 32'hCAFE_0101);
    apb_read(8'(I_PLL_LOW*4), d, e, r);
    check(d == 32'hCAFE_0101, "R5 pll low store", d, 32'hCAFE_0101);

    // R6: remap change attempt flagged, content kept; same value not flagged
    apb_write(8'(I_DDR*4), 32'h0000_0001, e, rj);
    check(rj == 1'b1, "R6 reject pulse on change", 32'(rj), 32'h1);
    @(negedge pclk);
    check(remap_reject == 1'b0, "R6 reject lasts one cycle", 32'(remap_reject), 32'h0);
    apb_read(8'(I_DDR*4), d, e, r);
    check(d == 32'h0, "R6 remap word kept", d, 32'h0);
    apb_write(8'(I_REMAP*4), 32'h0, e, rj);
    check(rj == 1'b0, "R6 no reject on same value", 32'(rj), 32'h0);

    // R1: low address bits ignored
    apb_write(8'(4*4 + 3), 32'h1234_5678, e, rj); model_write(4, 32'h1234_5678);
    apb_read(8'(4*4 + 1), d, e, r);
    check(d == 32'h1234_5678, "R1 low bits ignored", d, 32'h1234_5678);

    // R2: out-of-range read
    apb_read(8'hFC, d, e, r);
    check(d == 32'h0 && e && r, "R2 oor read zero+err", d, 32'h0);

    // R3: out-of-range write aliasing index 3 (word 35) changes nothing
    apb_write(8'(35*4), 32'hDEAD_BEEF, e, rj);
    check(e == 1'b1, "R3 oor write err", 32'(e), 32'h1);
    apb_read(8'(3*4), d, e, r);
    check(d == model[3], "R3 alias word unchanged", d, model[3]);

    // R9: plain word stores all bits
    apb_write(8'(20*4), 32'hFFFF_FFFF, e, rj); model_write(20, 32'hFFFF_FFFF);
    apb_read(8'(20*4), d, e, r);
    check(d == 32'hFFFF_FFFF, "R9 plain word all ones", d, 32'hFFFF_FFFF);

    // Random mix, R1 R2 R3 R6 R10
    for (int n = 0; n < 300; n++) begin
      w = $urandom_range(NUM_REGS + 5, 0);
      v = $urandom;
      if ($urandom_range(1, 0) == 1) begin
        logic exp_rj;
        exp_rj = (w < NUM_REGS) && is_locked(int'(w)) && (v != model[w]);
        apb_write(8'(w*4 + $urandom_range(3, 0)), v, e, rj);
        check(e == (w >= NUM_REGS), "R3/R10 random write err", 32'(e), 32'(w >= NUM_REGS));
        check(rj == exp_rj, "R6 random reject", 32'(rj), 32'(exp_rj));
        model_write(int'(w), v);
      end else begin
        logic [31:0] exp_d;
        exp_d = (w < NUM_REGS) ? model[w] : 32'h0;
        apb_read(8'(w*4 + $urandom_range(3, 0)), d, e, r);
        check(d == exp_d && e == (w >= NUM_REGS) && r, "R1/R2/R10 random read", d, exp_d);
      end
    end

    // R11: reset restores all words
    apb_write(8'(I_DIV*4), 32'h0, e, rj);
    do_reset();
    read_all("R11 reset restores");

    // R7 R8: divider reset value for every legal divisor pair
    apb_read(8'(I_DIV*4), d, e, r);
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 6; j++) begin
        logic [31:0] exp_div;
        exp_div = (code_of_log2(i) << 5) | (code_of_log2(j) << 2);
        check(sw_rdata[i*6+j] == exp_div, "R7/R8 divider code", sw_rdata[i*6+j], exp_div);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule